// File: doc/BRIEF.md
# Complementary Output Dead-Time Generator

This block turns a single PWM reference into a complementary pair of pin drives, a main drive and a negated drive. Whenever the reference changes level, the drive that was on switches off at once. The opposite drive switches on only after a programmable gap, so the two switches of a half bridge are never on together. The gap comes from an 8-bit setup code with a piecewise, non-linear encoding. It is counted in ticks of a sampling enable, a one-cycle strobe that the surrounding timer supplies.

The block also handles the idle sequence. When the master output enable is low, one of two behaviours applies. If the keep-control select is 0, both drives go low and the block raises a request for the pad to float. If the select is 1, the block keeps control of the pins: both drives are held inactive for one gap and then take two programmed idle levels. All pins are plain control signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `cdt_pair`

## Requirements
- R1: If code bit 7 is 0, the gap is the code value in ticks (0 to 127).
- R2: If code bits 7:6 are 10, the gap is (64 + code[5:0]) x 2 ticks.
- R3: If code bits 7:5 are 110, the gap is (32 + code[4:0]) x 8 ticks.
- R4: If code bits 7:5 are 111, the gap is (32 + code[4:0]) x 16 ticks.
- R5: `pwm_in` is sampled on each clock edge. On the edge that sees it rise, `drv_neg` goes to 0. `drv_main` goes to 1 after the gap has elapsed in ticks counted on later edges, or on that same edge if the gap is 0. A fall works the same way with the two drives swapped.
- R6: `drv_main` and `drv_neg` are never 1 in the same cycle.
- R7: If the reference changes again before the gap ends, the timer restarts from the full gap. The drive that was waiting stays 0 for the whole short pulse.
- R8: The code is captured on the reference edge that starts a gap. Changing the code during a gap leaves that gap unchanged and applies from the next edge.
- R9: Only clock edges with `tick_en` high advance a gap. The edge that starts a gap does not count.
- R10: With `out_en` 0 and `idle_keep` 0, both drives are 0 and `hiz_req` is 1, whatever the reference does.
- R11: With `out_en` 0 and `idle_keep` 1, `hiz_req` is 0. Both drives are 0 at once. After as many ticks as the current code's gap, the drives take `idle_main` and `idle_neg`.
- R12: After reset, with `out_en` 1 and `pwm_in` 0, `drv_neg` is 1, `drv_main` is 0 and `hiz_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Dead-time sampling strobe, one tick per high cycle |
| pwm_in | input | 1 | PWM reference level |
| dt_code | input | 8 | Dead-time setup code |
| out_en | input | 1 | Master output enable |
| idle_keep | input | 1 | Off-state select: 1 keeps control of the pins when disabled |
| idle_main | input | 1 | Idle level of the main drive |
| idle_neg | input | 1 | Idle level of the negated drive |
| drv_main | output | 1 | Main drive |
| drv_neg | output | 1 | Negated drive |
| hiz_req | output | 1 | Request that the pads float |

## Verification
A reference edge and the drop of `out_en` can land on the same clock. The reference timer and the idle timer then both load the gap in one cycle and count down side by side. The bench provokes this by lowering `pwm_in` and `out_en` at the same moment with `idle_keep` set. It checks that the idle levels appear after exactly the gap in ticks. After the gap, it raises `out_en` again and expects the negated drive at once, because the reference timer finished its own gap in the background.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int CODE_W = 8;
  // widest gap is 63 * 16 = 1008 ticks
  localparam int DT_W   = 10;

  function automatic logic [DT_W-1:0] gap_ticks(input logic [CODE_W-1:0] c);
    logic [DT_W-1:0] g;
    if (!c[7])
      g = {{(DT_W-CODE_W){1'b0}}, c};
    else if (!c[6])
      g = (10'd64 + {4'b0, c[5:0]}) << 1;
    else if (!c[5])
      g = (10'd32 + {5'b0, c[4:0]}) << 3;
    else
      g = (10'd32 + {5'b0, c[4:0]}) << 4;
    return g;
  endfunction
endpackage

// File: rtl/cdt_decode.sv
module cdt_decode
  import cdt_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [DT_W-1:0]   ticks
);
  assign ticks = gap_ticks(code);
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         tick,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (tick && cnt != 0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R8: a load captures the value presented on that edge
  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
  // R9: without a tick the count holds
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt));
  // R9: a tick removes exactly one unit
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && busy) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/cdt_drive.sv
module cdt_drive (
  input  logic ref_lvl,
  input  logic run_busy,
  input  logic en,
  input  logic keep,
  input  logic idle_busy,
  input  logic lvl_main,
  input  logic lvl_neg,
  output logic o_main,
  output logic o_neg,
  output logic o_hiz
);
  always_comb begin
    o_main = 1'b0;
    o_neg  = 1'b0;
    o_hiz  = 1'b0;
    if (en) begin
      o_main = ref_lvl & ~run_busy;
      o_neg  = ~ref_lvl & ~run_busy;
    end else if (!keep) begin
      o_hiz = 1'b1;
    end else if (!idle_busy) begin
      o_main = lvl_main;
      o_neg  = lvl_neg;
    end
  end
endmodule

// File: rtl/cdt_pair.sv
module cdt_pair
  import cdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              pwm_in,
  input  logic [CODE_W-1:0] dt_code,
  input  logic              out_en,
  input  logic              idle_keep,
  input  logic              idle_main,
  input  logic              idle_neg,
  output logic              drv_main,
  output logic              drv_neg,
  output logic              hiz_req
);
  localparam int N_TM = 2;  // 0: reference gap, 1: idle-entry gap

  logic            ref_q;
  logic            ref_edge;
  logic [DT_W-1:0] gap_len;
  logic [N_TM-1:0] tm_load;
  logic [N_TM-1:0] tm_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= pwm_in;
  end

  assign ref_edge   = pwm_in ^ ref_q;
  assign tm_load[0] = ref_edge;
  // idle timer is kept primed while enabled and runs once disabled
  assign tm_load[1] = out_en;

  cdt_decode u_dec (
    .code  (dt_code),
    .ticks (gap_len)
  );

  for (genvar g = 0; g < N_TM; g++) begin : g_tm
    cdt_timer #(.W(DT_W)) u_tm (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tm_load[g]),
      .tick     (tick_en),
      .load_val (gap_len),
      .busy     (tm_busy[g])
    );
  end

  cdt_drive u_drv (
    .ref_lvl   (ref_q),
    .run_busy  (tm_busy[0]),
    .en        (out_en),
    .keep      (idle_keep),
    .idle_busy (tm_busy[1]),
    .lvl_main  (idle_main),
    .lvl_neg   (idle_neg),
    .o_main    (drv_main),
    .o_neg     (drv_neg),
    .o_hiz     (hiz_req)
  );

  // R6: complementary drives never overlap while enabled
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> !(drv_main && drv_neg));
  // R5: an edge with a nonzero gap leaves both drives off
  p_edge_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge && gap_len != 0) |=> (!out_en || (!drv_main && !drv_neg)));
  // R10: a float request never coexists with an active drive
  p_hiz_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_req |-> (!drv_main && !drv_neg));
  // R11: keeping control never floats the pads
  p_keep_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en && idle_keep) |-> !hiz_req);
  // R11: first disabled cycle is inactive when a gap is programmed
  p_idle_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && gap_len != 0) ##1 (!out_en && idle_keep && $stable(dt_code))
      |-> (!drv_main && !drv_neg));
endmodule

// File: tb/cdt_pair_bench.sv
module cdt_pair_bench;
  logic       clk = 1'b0;
  logic       rst_n, tick_en, pwm_in, out_en, idle_keep, idle_main, idle_neg;
  logic [7:0] dt_code;
  logic       drv_main, drv_neg, hiz_req;

  int n_cmp = 0;
  int n_bad = 0;
  int phase = 0;
  int tdiv  = 1;

  always #4 clk = ~clk;

  cdt_pair u_cdt_pair (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwm_in(pwm_in),
    .dt_code(dt_code), .out_en(out_en), .idle_keep(idle_keep),
    .idle_main(idle_main), .idle_neg(idle_neg),
    .drv_main(drv_main), .drv_neg(drv_neg), .hiz_req(hiz_req)
  );

  function automatic int exp_dt(input int c);
    if (c < 128)      return c;
    else if (c < 192) return (c - 64) * 2;
    else if (c < 224) return (c - 160) * 8;
    else              return (c - 192) * 16;
  endfunction

  function automatic string range_tag(input int c);
    if (c < 128)      return "R1";
    else if (c < 192) return "R2";
    else if (c < 224) return "R3";
    else              return "R4";
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_tick();
    phase = (phase + 1) % tdiv;
    tick_en = (phase == 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Apply a reference edge and count ticks until the waiting drive turns on.
  task automatic meas(input bit rising, input int chg, output int ticks, output bit bad);
    ticks = 0;
    bad = 0;
    @(negedge clk);
    pwm_in = rising;
    drive_tick();
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk);
      if (drv_main && drv_neg) bad = 1;
      if (rising ? drv_neg : drv_main) bad = 1;
      if (rising ? drv_main : drv_neg) break;
      if (g == 0 && chg >= 0) dt_code = 8'(chg);
      drive_tick();
      if (tick_en) ticks++;
    end
  endtask

  // Drop out_en with idle_keep set; count ticks until the idle levels show.
  task automatic idle_meas(input bit flip, input bit im, input bit in, output int ticks, output bit bad);
    ticks = 0;
    bad = 0;
    @(negedge clk);
    out_en = 1'b0;
    if (flip) pwm_in = ~pwm_in;
    for (int g = 0; g < 5000; g++) begin
      #1;
      if (hiz_req) bad = 1;
      if (drv_main == im && drv_neg == in) break;
      if (drv_main || drv_neg) bad = 1;
      drive_tick();
      if (tick_en) ticks++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int  t;
    bit  bad;
    int  codes[3];
    rst_n = 0; tick_en = 1; pwm_in = 0; out_en = 1; idle_keep = 0;
    idle_main = 0; idle_neg = 0; dt_code = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(drv_neg == 1 && drv_main == 0 && hiz_req == 0, "R12 reset drives",
        {drv_main, drv_neg, hiz_req}, 3'b010);

    // R1-R4 (range sweep) with R5 and R6 on every edge
    for (int c = 0; c < 256; c++) begin
      dt_code = 8'(c);
      meas(1'b1, -1, t, bad);
      chk(t == exp_dt(c), {range_tag(c), " rise gap"}, t, exp_dt(c));
      chk(!bad, "R5 R6 rise order", bad, 0);
      meas(1'b0, -1, t, bad);
      chk(t == exp_dt(c), {range_tag(c), " fall gap"}, t, exp_dt(c));
      chk(!bad, "R5 R6 fall order", bad, 0);
    end

    // R9 sparse ticks
    tdiv = 3;
    dt_code = 8'd9;
    meas(1'b1, -1, t, bad);
    chk(t == 9 && !bad, "R9 sparse rise", t, 9);
    meas(1'b0, -1, t, bad);
    chk(t == 9 && !bad, "R9 sparse fall", t, 9);
    tdiv = 1;

    // R7 short pulse
    dt_code = 8'd10;
    @(negedge clk);
    pwm_in = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!drv_main && !drv_neg, "R7 short pulse off", {drv_main, drv_neg}, 0);
    end
    meas(1'b0, -1, t, bad);
    chk(t == 10, "R7 restart gap", t, 10);
    chk(!bad, "R7 main never on", bad, 0);

    // R8 code change mid-gap
    dt_code = 8'd20;
    meas(1'b1, 3, t, bad);
    chk(t == 20, "R8 old code kept", t, 20);
    meas(1'b0, -1, t, bad);
    chk(t == 3, "R8 new code next edge", t, 3);

    // R10 release to float
    @(negedge clk);
    idle_keep = 1'b0;
    out_en = 1'b0;
    #1;
    chk(!drv_main && !drv_neg && hiz_req, "R10 float", {drv_main, drv_neg, hiz_req}, 3'b001);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k == 1) pwm_in = 1'b1;
      if (k == 3) pwm_in = 1'b0;
      chk(!drv_main && !drv_neg && hiz_req, "R10 ref ignored", {drv_main, drv_neg, hiz_req}, 3'b001);
    end
    @(negedge clk);
    out_en = 1'b1;
    pwm_in = 1'b1;
    repeat (30) @(negedge clk);

    // R11 keep control, idle levels after one gap
    codes[0] = 0; codes[1] = 6; codes[2] = 200;
    for (int lv = 1; lv < 4; lv++) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        dt_code = 8'(codes[i]);
        idle_keep = 1'b1;
        idle_main = lv[1];
        idle_neg = lv[0];
        out_en = 1'b1;
        repeat (2) @(negedge clk);
        idle_meas(1'b0, lv[1], lv[0], t, bad);
        chk(t == exp_dt(codes[i]), "R11 idle gap", t, exp_dt(codes[i]));
        chk(!bad, "R11 inactive then idle", bad, 0);
        out_en = 1'b1;
        @(negedge clk);
        chk(drv_main == 1 && drv_neg == 0, "R5 resume after idle", {drv_main, drv_neg}, 2'b10);
      end
    end

    // R11 with R5: reference edge on the same cycle as disable
    @(negedge clk);
    dt_code = 8'd4;
    idle_main = 1'b1;
    idle_neg = 1'b1;
    repeat (2) @(negedge clk);
    idle_meas(1'b1, 1'b1, 1'b1, t, bad);
    chk(t == 4 && !bad, "R11 idle with concurrent edge", t, 4);
    repeat (2) @(negedge clk);
    out_en = 1'b1;
    #1;
    chk(drv_neg == 1 && drv_main == 0, "R5 background gap finished", {drv_main, drv_neg}, 2'b01);

    summary();
    $finish;
  end
endmodule